// File: doc/BRIEF.md
# Dual-Channel Indexed Register Pointer and Command Decoder

This block is the bus front end of a two-channel serial controller. Each channel has two byte-wide bus ports. The control port reaches a bank of sixteen registers through a pointer, and the data port always reaches the receive/transmit data slot at index 8. The pointer is a single one-shot value shared by both channels.

A control write made while the pointer is zero lands in the command register. Bits [2:0] of that byte load the pointer. Bits [5:3] carry a command, and code 1 adds 8 to the pointer. The next access uses the pointer, and the pointer then falls back to zero. Commands that clear interrupt-pending state, arm the next-character receive interrupt or reset an error become one-cycle strobes for the channel that was written.

Read data is registered. The block also holds the few registers whose storage rules belong to the access path:
- The interrupt vector (index 2) and the master control byte (index 9) are shared by both channels.
- The per-channel status-latch mask byte (index 15) is stored for each channel and can be read back.
- The status read (index 0) merges live status with values frozen at the last external/status event.

Top module: `sio_regptr`

## Requirements
- R1: After reset, the pointer is 0, all command strobes are low, index 1 of either channel reads 0x01 (bit 0 = all-sent, bit 7 = receive error), and the shared vector reads 0x00.
- R2: A control write (port_i=0) while the pointer is 0 loads the pointer with data bits [2:0]. If the command field, bits [5:3], equals 1, the pointer is loaded with 8 plus bits [2:0].
- R3: The access after the pointer is set goes to that index. Every read, and every write that does not land on index 0, returns the pointer to 0.
- R4: A data-port access (port_i=1) always uses index 8, whatever the pointer holds. A data read returns the selected channel's receive byte, and the access still clears the pointer.
- R5: Command 2 gives a one-cycle pulse on ext_clr_o for the written channel, and it releases that channel's status latch.
- R6: Command 4 gives a one-cycle pulse on rx_arm_o, and command 5 gives a one-cycle pulse on tx_clr_o, each for the written channel.
- R7: Command 6 gives a one-cycle pulse on err_clr_o and clears bit 7 of that channel's index-1 register. An err_set_i pulse sets that bit.
- R8: Commands 0, 3 and 7 raise no strobe.
- R9: The pointer is shared: a pointer set through one channel is used by the next access on the other channel.
- R10: A write to index 2 (vector) or index 9 (master control) through either channel reads back the same value on both channels.
- R11: A write to index 15 is stored for the written channel only and reads back at index 15 of that channel.
- R12: A read of index 0 returns live stat_i, except that bits set in the latch mask return the stat_i value captured on the last ext_evt_i pulse. The mask is the index-15 value at the time of that pulse.
- R13: rdata_o updates in the cycle after the read strobe. Indices without storage (3-7, 10-14) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_i | input | 1 | Channel select (0 or 1) |
| port_i | input | 1 | 0 = control port, 1 = data port |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access (wins over rd_i) |
| wdata_i | input | 8 | Write data byte |
| stat_i | input | 16 | Live status byte per channel, channel c at [8c+7:8c] |
| ext_evt_i | input | 2 | External/status event pulse per channel, captures the latch |
| err_set_i | input | 2 | Receive error pulse per channel, sets index-1 bit 7 |
| rx_data_i | input | 16 | Receive byte per channel, channel c at [8c+7:8c] |
| ptr_o | output | 4 | Current shared pointer |
| idx_o | output | 4 | Index used by an access in this cycle |
| rdata_o | output | 8 | Registered read data |
| ext_clr_o | output | 2 | Per-channel external/status clear strobe |
| rx_arm_o | output | 2 | Per-channel arm next-character receive interrupt strobe |
| tx_clr_o | output | 2 | Per-channel transmit-pending clear strobe |
| err_clr_o | output | 2 | Per-channel error reset strobe |

## Verification
The assertions check on every cycle that the pointer returns to zero after any read or any non-command write, and that a command write loads the low pointer bits from the data byte. They also check that at most one command strobe is high at a time, that no strobe appears without a command write on the cycle before, and that an error reset leaves the error bit clear. The bench scenarios cover what depends on values written earlier: that the pointer is shared across channels, that the vector and master control bytes read back the same from both channels, that the index-15 storage is kept per channel, and that the status read merges latched and live bits, including the release of the latch by command 2.

// File: rtl/sio_regptr_pkg.sv
package sio_regptr_pkg;
  localparam int DW   = 8;
  localparam int IDXW = 4;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_PT_HI   = 3'd1,
    CMD_EXT_CLR = 3'd2,
    CMD_ABORT   = 3'd3,
    CMD_RX_ARM  = 3'd4,
    CMD_TX_CLR  = 3'd5,
    CMD_ERR_CLR = 3'd6,
    CMD_IUS     = 3'd7
  } cmd_e;

  localparam logic [IDXW-1:0] IDX_CMD   = 4'd0;
  localparam logic [IDXW-1:0] IDX_STAT1 = 4'd1;
  localparam logic [IDXW-1:0] IDX_VEC   = 4'd2;
  localparam logic [IDXW-1:0] IDX_DATA  = 4'd8;
  localparam logic [IDXW-1:0] IDX_MCTL  = 4'd9;
  localparam logic [IDXW-1:0] IDX_LMSK  = 4'd15;

  localparam int ERR_BIT  = 7;
  localparam int SENT_BIT = 0;
endpackage

// File: rtl/sio_regptr_ptr.sv
module sio_regptr_ptr
  import sio_regptr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            port_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [IDXW-1:0] ptr_o,
  output logic [IDXW-1:0] idx_o,
  output logic            cmd_vld_o,
  output cmd_e            cmd_o
);
  logic [IDXW-1:0] ptr_q;

  assign ptr_o     = ptr_q;
  assign idx_o     = port_i ? IDX_DATA : ptr_q;
  assign cmd_vld_o = wr_i && !port_i && (ptr_q == IDX_CMD);
  assign cmd_o     = cmd_e'(wdata_i[5:3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (cmd_vld_o)      ptr_q <= {cmd_o == CMD_PT_HI, wdata_i[2:0]};
    else if (rd_i || wr_i)   ptr_q <= '0;
  end

  // R3
  ptr_clr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> (ptr_o == '0));
  // R3
  ptr_clr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (port_i || ptr_o != '0)) |=> (ptr_o == '0));
  // R2
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !port_i && ptr_o == '0) |=> (ptr_o[2:0] == $past(wdata_i[2:0])));
endmodule

// File: rtl/sio_regptr_chan.sv
module sio_regptr_chan
  import sio_regptr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic            cmd_vld_i,
  input  cmd_e            cmd_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   stat_i,
  input  logic            ext_evt_i,
  input  logic            err_set_i,
  output logic [DW-1:0]   rr0_o,
  output logic [DW-1:0]   rr1_o,
  output logic [DW-1:0]   lmsk_o,
  output logic            ext_clr_o,
  output logic            rx_arm_o,
  output logic            tx_clr_o,
  output logic            err_clr_o
);
  logic          hit;
  logic [DW-1:0] lmsk_q, lat_msk_q, lat_val_q, rr1_q;

  assign hit = sel_i && cmd_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_clr_o <= 1'b0;
      rx_arm_o  <= 1'b0;
      tx_clr_o  <= 1'b0;
      err_clr_o <= 1'b0;
    end else begin
      ext_clr_o <= hit && cmd_i == CMD_EXT_CLR;
      rx_arm_o  <= hit && cmd_i == CMD_RX_ARM;
      tx_clr_o  <= hit && cmd_i == CMD_TX_CLR;
      err_clr_o <= hit && cmd_i == CMD_ERR_CLR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lmsk_q <= '0;
    else if (sel_i && wr_i && idx_i == IDX_LMSK) lmsk_q <= wdata_i;
  end

  // a new event wins over a same-cycle release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_msk_q <= '0;
      lat_val_q <= '0;
    end else if (ext_evt_i) begin
      lat_msk_q <= lmsk_q;
      lat_val_q <= stat_i;
    end else if (hit && cmd_i == CMD_EXT_CLR) begin
      lat_msk_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr1_q <= DW'(1) << SENT_BIT;
    else if (err_set_i) rr1_q[ERR_BIT] <= 1'b1;
    else if (hit && cmd_i == CMD_ERR_CLR) rr1_q[ERR_BIT] <= 1'b0;
  end

  assign rr0_o  = (stat_i & ~lat_msk_q) | (lat_val_q & lat_msk_q);
  assign rr1_o  = rr1_q;
  assign lmsk_o = lmsk_q;

  // R7
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |-> (!rr1_q[ERR_BIT] || $past(err_set_i)));
endmodule

// File: rtl/sio_regptr.sv
module sio_regptr
  import sio_regptr_pkg::*;
#(
  parameter  int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHW-1:0]    chan_i,
  input  logic              port_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NCH*DW-1:0] stat_i,
  input  logic [NCH-1:0]    ext_evt_i,
  input  logic [NCH-1:0]    err_set_i,
  input  logic [NCH*DW-1:0] rx_data_i,
  output logic [IDXW-1:0]   ptr_o,
  output logic [IDXW-1:0]   idx_o,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    ext_clr_o,
  output logic [NCH-1:0]    rx_arm_o,
  output logic [NCH-1:0]    tx_clr_o,
  output logic [NCH-1:0]    err_clr_o
);
  logic          cmd_vld;
  cmd_e          cmd;
  logic [DW-1:0] rr0 [NCH];
  logic [DW-1:0] rr1 [NCH];
  logic [DW-1:0] lmsk [NCH];
  logic [DW-1:0] vec_q, mctl_q, rdata_q;

  sio_regptr_ptr u_ptr (
    .clk_i, .rst_ni, .rd_i, .wr_i, .port_i, .wdata_i,
    .ptr_o, .idx_o, .cmd_vld_o(cmd_vld), .cmd_o(cmd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sio_regptr_chan u_chan (
      .clk_i, .rst_ni,
      .sel_i     (chan_i == CHW'(g)),
      .wr_i,
      .cmd_vld_i (cmd_vld),
      .cmd_i     (cmd),
      .idx_i     (idx_o),
      .wdata_i,
      .stat_i    (stat_i[g*DW +: DW]),
      .ext_evt_i (ext_evt_i[g]),
      .err_set_i (err_set_i[g]),
      .rr0_o     (rr0[g]),
      .rr1_o     (rr1[g]),
      .lmsk_o    (lmsk[g]),
      .ext_clr_o (ext_clr_o[g]),
      .rx_arm_o  (rx_arm_o[g]),
      .tx_clr_o  (tx_clr_o[g]),
      .err_clr_o (err_clr_o[g])
    );
  end

  // shared copies: any channel writes, every channel reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      mctl_q <= '0;
    end else if (wr_i) begin
      if (idx_o == IDX_VEC)  vec_q  <= wdata_i;
      if (idx_o == IDX_MCTL) mctl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i && !wr_i) begin
      unique case (idx_o)
        IDX_CMD:   rdata_q <= rr0[chan_i];
        IDX_STAT1: rdata_q <= rr1[chan_i];
        IDX_VEC:   rdata_q <= vec_q;
        IDX_DATA:  rdata_q <= rx_data_i[chan_i*DW +: DW];
        IDX_MCTL:  rdata_q <= mctl_q;
        IDX_LMSK:  rdata_q <= lmsk[chan_i];
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_clr_o, rx_arm_o, tx_clr_o, err_clr_o}));
  // R5
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{ext_clr_o, rx_arm_o, tx_clr_o, err_clr_o}) |-> $past(cmd_vld));
endmodule

// File: tb/sio_regptr_tb_top.sv
module sio_regptr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan = 1'b0, port = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] stat = '0, rxd = '0;
  logic [1:0]  evt = '0, eset = '0;
  logic [3:0]  ptr, idx;
  logic [7:0]  rdata;
  logic [1:0]  ext_clr, rx_arm, tx_clr, err_clr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_regptr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_i(chan), .port_i(port), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .stat_i(stat), .ext_evt_i(evt), .err_set_i(eset), .rx_data_i(rxd),
    .ptr_o(ptr), .idx_o(idx), .rdata_o(rdata), .ext_clr_o(ext_clr), .rx_arm_o(rx_arm),
    .tx_clr_o(tx_clr), .err_clr_o(err_clr)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(logic c, logic [7:0] v);
    @(negedge clk); chan = c; port = 1'b0; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_acc(logic c, logic p, output logic [7:0] v);
    @(negedge clk); chan = c; port = p; rd = 1'b1;
    @(negedge clk); rd = 1'b0; port = 1'b0; v = rdata;
  endtask

  task automatic strobes(string req, logic [7:0] exp);
    chk(req, {ext_clr, rx_arm, tx_clr, err_clr}, exp);
    @(negedge clk);
    chk({req, " one-cycle"}, {ext_clr, rx_arm, tx_clr, err_clr}, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 ptr", {4'h0, ptr}, 8'h00);
    chk("R1 strobes", {ext_clr, rx_arm, tx_clr, err_clr}, 8'h00);
    ctl_wr(1'b0, 8'h01); rd_acc(1'b0, 1'b0, v); chk("R1 rr1", v, 8'h01);
    ctl_wr(1'b1, 8'h02); rd_acc(1'b1, 1'b0, v); chk("R1 vector", v, 8'h00);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    ctl_wr(1'b0, 8'h05); chk("R2 ptr low", {4'h0, ptr}, 8'h05);
    ctl_wr(1'b0, 8'h00); chk("R3 write clears ptr", {4'h0, ptr}, 8'h00);
    ctl_wr(1'b0, 8'h0F); chk("R2 point high", {4'h0, ptr}, 8'h0F);
    ctl_wr(1'b0, 8'h5A); chk("R3 ptr after write", {4'h0, ptr}, 8'h00);
    ctl_wr(1'b0, 8'h0F); rd_acc(1'b0, 1'b0, v); chk("R11 lmsk ch0", v, 8'h5A);
    chk("R3 ptr after read", {4'h0, ptr}, 8'h00);
    ctl_wr(1'b1, 8'h0F); rd_acc(1'b1, 1'b0, v); chk("R11 lmsk ch1 separate", v, 8'h00);
    ctl_wr(1'b0, 8'h1C); rd_acc(1'b0, 1'b0, v); chk("R13 empty index", v, 8'h00);
  endtask

  task automatic t_shared;
    logic [7:0] v;
    ctl_wr(1'b0, 8'h02); ctl_wr(1'b1, 8'hA7);
    chk("R9 ptr used by other chan", {4'h0, ptr}, 8'h00);
    ctl_wr(1'b1, 8'h02); rd_acc(1'b0, 1'b0, v); chk("R10 vector ch0", v, 8'hA7);
    ctl_wr(1'b0, 8'h02); rd_acc(1'b1, 1'b0, v); chk("R10 vector ch1", v, 8'hA7);
    ctl_wr(1'b1, 8'h09); ctl_wr(1'b1, 8'h3C);
    ctl_wr(1'b1, 8'h09); rd_acc(1'b0, 1'b0, v); chk("R10 mctl ch0", v, 8'h3C);
  endtask

  task automatic t_data;
    logic [7:0] v;
    rxd = 16'h2211;
    ctl_wr(1'b0, 8'h05);
    @(negedge clk); chan = 1'b1; port = 1'b1; rd = 1'b1;
    #1 chk("R4 data index", {4'h0, idx}, 8'h08);
    @(negedge clk); rd = 1'b0; port = 1'b0; v = rdata;
    chk("R4 rx ch1", v, 8'h22);
    chk("R4 ptr cleared", {4'h0, ptr}, 8'h00);
    rd_acc(1'b0, 1'b1, v); chk("R13 rx ch0", v, 8'h11);
  endtask

  task automatic t_cmds;
    logic [7:0] v;
    ctl_wr(1'b1, 8'h10); strobes("R5 ext_clr ch1", 8'h80);
    ctl_wr(1'b0, 8'h20); strobes("R6 rx_arm ch0", 8'h10);
    ctl_wr(1'b1, 8'h28); strobes("R6 tx_clr ch1", 8'h08);
    @(negedge clk); eset = 2'b01; @(negedge clk); eset = 2'b00;
    ctl_wr(1'b0, 8'h01); rd_acc(1'b0, 1'b0, v); chk("R7 err set", v, 8'h81);
    ctl_wr(1'b0, 8'h30); strobes("R7 err_clr ch0", 8'h01);
    ctl_wr(1'b0, 8'h01); rd_acc(1'b0, 1'b0, v); chk("R7 err cleared", v, 8'h01);
    ctl_wr(1'b0, 8'h00); strobes("R8 cmd0", 8'h00);
    ctl_wr(1'b1, 8'h1B); strobes("R8 cmd3", 8'h00);
    chk("R8 cmd3 ptr", {4'h0, ptr}, 8'h03);
    rd_acc(1'b1, 1'b0, v);
    ctl_wr(1'b0, 8'h38); strobes("R8 cmd7", 8'h00);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    stat = 16'h0020;
    ctl_wr(1'b0, 8'h0F); ctl_wr(1'b0, 8'h28);
    @(negedge clk); evt = 2'b01; @(negedge clk); evt = 2'b00;
    stat = 16'h000C;
    rd_acc(1'b0, 1'b0, v); chk("R12 latched merge", v, 8'h24);
    ctl_wr(1'b0, 8'h10); @(negedge clk);
    rd_acc(1'b0, 1'b0, v); chk("R5 latch released", v, 8'h0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_shared();
    t_data();
    t_cmds();
    t_latch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule